// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sits between a host's memory strobes and a battery-backed byte-wide static memory. It watches two digital supply flags: one says the supply has sagged below the level at which the memory must stop taking accesses, and a second, lower one says the supply is too weak to power the array at all. The two comparators that make these flags, and the switch that moves the array onto its cell, sit outside the block. From the flags the block runs a four-state sequence (normal, deselected, battery, recovering). It gates the host's chip-enable and write-enable, tells the data pads to float, and drives the battery-select switch.

When the supply returns, the memory is not released at once. A recovery timer of `TREC_CYC` clock cycles must run to completion with the supply good before requests pass again. If the supply dips during that interval, the timer starts over. A reset leaves the block deselected, so one full recovery interval separates reset from the first access. A fast-fall indication lets the bench model the late trip of a supply that collapses faster than the comparator can follow: while it is set, the deselect trip is held back by `LAG_CYC` cycles.

Top module: `pfs_supervisor`

## Requirements
- R1: While reset is low, the block reports status 01 (deselected), with the gated enables low, the output-disable high and the battery select low. Status 00 (normal) is only ever entered from status 11 (recovering).
- R2: In status 00, the gated chip-enable equals the chip-enable request and the gated write-enable equals the write-enable request, in the same cycle.
- R3: In status 00, with the fast-fall flag low and the battery flag low, a deselect flag seen at a clock edge makes the status 01 after that edge. In every status other than 00, the gated chip-enable is low and the output-disable is high.
- R4: In every status other than 00, the gated write-enable is low whatever the requests are.
- R5: A battery flag seen at a clock edge makes the status 10, with battery select high, after that edge. A low battery flag while in status 10 leaves status 10 at the next edge: to 01 if the deselect flag is still high, otherwise to 11.
- R6: When both flags are low in status 01 or 10, the next status is 11. Status 11 lasts exactly `TREC_CYC` cycles and is then followed by 00, so 00 is reached `TREC_CYC`+1 edges after reset release with both flags low.
- R7: A deselect flag during status 11 moves the status to 01. The next recovery interval is a full `TREC_CYC` cycles.
- R8: In status 00, while the deselect and fast-fall flags are both held high, the status stays 00 for exactly `LAG_CYC` edges and becomes 01 at the next edge. If the fast-fall flag drops, the trip happens at the next edge.
- R9: A battery flag in status 00 moves the status straight to 10, without passing through 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_pfd_i | input | 1 | Supply is below the deselect threshold (synchronised, debounced) |
| below_so_i | input | 1 | Supply is below the battery switchover threshold (synchronised, debounced) |
| fast_fall_i | input | 1 | Supply is collapsing faster than the rated fall time; delays the deselect trip |
| ce_req_i | input | 1 | Host chip-enable request, active high |
| we_req_i | input | 1 | Host write-enable request, active high |
| ce_gated_o | output | 1 | Chip-enable passed to the memory |
| we_gated_o | output | 1 | Write-enable passed to the memory |
| out_dis_o | output | 1 | Forces the memory data pads to high impedance |
| bat_sel_o | output | 1 | Selects the battery as the array supply |
| status_o | output | 2 | 00 normal, 01 deselected, 10 battery, 11 recovering |

## Verification
The assertions take for granted that the battery flag is only ever high while the deselect flag is also high, because the switchover level lies below the deselect level. They also assume both flags arrive already synchronised, so each value is stable across a clock edge. The stimulus keeps to this rule: it forces the battery flag low whenever the deselect flag is low, and it changes every input only at the falling clock edge. The sweep holds each flag level for stretches long enough that recovery intervals both finish and get interrupted.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef enum logic [1:0] {
      PFS_RUN   = 2'b00,
      PFS_DESEL = 2'b01,
      PFS_BATT  = 2'b10,
      PFS_RECOV = 2'b11
   } pfs_state_t;
endpackage

// File: rtl/pfs_sat_counter.sv
// Saturating up-counter: clears while clr is high, stops at LIMIT.
module pfs_sat_counter #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic done
);
   localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   initial begin
      if (LIMIT < 0) $fatal(1, "pfs_sat_counter: LIMIT must be >= 0");
   end

   assign done = (cnt == LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (!done)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pfs_fsm.sv
// Supply sequence register and next-state logic.
module pfs_fsm
   import pfs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pfd,
   input  logic       so,
   input  logic       fast,
   input  logic       lag_done,
   input  logic       rec_done,
   output pfs_state_t state
);
   pfs_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         PFS_RUN: begin
            if (so)                              nxt = PFS_BATT;
            else if (pfd && (!fast || lag_done)) nxt = PFS_DESEL;
         end
         PFS_DESEL: begin
            if (so)        nxt = PFS_BATT;
            else if (!pfd) nxt = PFS_RECOV;
         end
         PFS_BATT: begin
            if (!so) nxt = pfd ? PFS_DESEL : PFS_RECOV;
         end
         PFS_RECOV: begin
            if (so)            nxt = PFS_BATT;
            else if (pfd)      nxt = PFS_DESEL;
            else if (rec_done) nxt = PFS_RUN;
         end
         default: nxt = PFS_DESEL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PFS_DESEL;
      else        state <= nxt;
   end
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
   import pfs_pkg::*;
#(
   parameter int TREC_CYC = 4000000,
   parameter int LAG_CYC  = 20000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       below_pfd_i,
   input  logic       below_so_i,
   input  logic       fast_fall_i,
   input  logic       ce_req_i,
   input  logic       we_req_i,
   output logic       ce_gated_o,
   output logic       we_gated_o,
   output logic       out_dis_o,
   output logic       bat_sel_o,
   output logic [1:0] status_o
);
   localparam int REC_LIMIT = TREC_CYC - 1;

   initial begin
      if (TREC_CYC < 1) $fatal(1, "pfs_supervisor: TREC_CYC must be >= 1");
      if (LAG_CYC < 0)  $fatal(1, "pfs_supervisor: LAG_CYC must be >= 0");
   end

   pfs_state_t state;
   logic       lag_done;
   logic       rec_done;
   logic       running;

   assign running = (state == PFS_RUN);

   pfs_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .pfd      (below_pfd_i),
      .so       (below_so_i),
      .fast     (fast_fall_i),
      .lag_done (lag_done),
      .rec_done (rec_done),
      .state    (state)
   );

   pfs_sat_counter #(.LIMIT(REC_LIMIT)) u_rec (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state != PFS_RECOV),
      .done  (rec_done)
   );

   generate
      if (LAG_CYC > 0) begin : g_lag
         logic lag_clr;
         assign lag_clr = !(running && below_pfd_i && fast_fall_i);
         pfs_sat_counter #(.LIMIT(LAG_CYC)) u_lag (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (lag_clr),
            .done  (lag_done)
         );
      end else begin : g_nolag
         assign lag_done = 1'b1;
      end
   endgenerate

   assign ce_gated_o = running & ce_req_i;
   assign we_gated_o = running & we_req_i;
   assign out_dis_o  = !running;
   assign bat_sel_o  = (state == PFS_BATT);
   assign status_o   = state;
endmodule

// File: rtl/pfs_supervisor_chk.sv
module pfs_supervisor_chk #(
   parameter int TREC_CYC = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       below_pfd_i,
   input logic       below_so_i,
   input logic       fast_fall_i,
   input logic       ce_gated_o,
   input logic       we_gated_o,
   input logic       out_dis_o,
   input logic       bat_sel_o,
   input logic [1:0] status_o
);
   int unsigned recov_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                recov_run <= 0;
      else if (status_o == 2'b11) recov_run <= recov_run + 1;
      else                       recov_run <= 0;
   end

   // R4
   we_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o != 2'b00 |-> !we_gated_o);

   // R3
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o != 2'b00 |-> (!ce_gated_o && out_dis_o));

   // R3
   trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 2'b00 && below_pfd_i && !fast_fall_i && !below_so_i)
      |=> status_o == 2'b01);

   // R5
   batt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      below_so_i |=> bat_sel_o);

   // R5
   batt_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bat_sel_o && !below_so_i) |=> !bat_sel_o);

   // R1
   normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o == 2'b00 |-> ($past(status_o) == 2'b00 || $past(status_o) == 2'b11));

   // R6
   recov_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 2'b00 && $past(status_o) == 2'b11) |-> recov_run == TREC_CYC);
endmodule

bind pfs_supervisor pfs_supervisor_chk #(.TREC_CYC(TREC_CYC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .below_pfd_i (below_pfd_i),
   .below_so_i  (below_so_i),
   .fast_fall_i (fast_fall_i),
   .ce_gated_o  (ce_gated_o),
   .we_gated_o  (we_gated_o),
   .out_dis_o   (out_dis_o),
   .bat_sel_o   (bat_sel_o),
   .status_o    (status_o)
);

// File: tb/pfs_supervisor_test.sv
module pfs_supervisor_test;
   localparam int PERIOD = 10;
   localparam int TREC   = 6;
   localparam int LAG    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pfd = 1'b0, so = 1'b0, fast = 1'b0, ce = 1'b0, we = 1'b0;
   logic ce_g, we_g, odis, bsel;
   logic [1:0] st;

   int checks = 0;
   int fails  = 0;

   // bench model: 0 run, 1 desel, 2 batt, 3 recov
   int m_st  = 1;
   int m_rec = 0;
   int m_lag = 0;

   always #(PERIOD/2) clk = ~clk;

   pfs_supervisor #(.TREC_CYC(TREC), .LAG_CYC(LAG)) uut (
      .clk(clk), .rst_n(rst_n), .below_pfd_i(pfd), .below_so_i(so),
      .fast_fall_i(fast), .ce_req_i(ce), .we_req_i(we),
      .ce_gated_o(ce_g), .we_gated_o(we_g), .out_dis_o(odis),
      .bat_sel_o(bsel), .status_o(st));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      int nx;
      nx = m_st;
      case (m_st)
         0: if (so) nx = 2; else if (pfd && (!fast || m_lag == LAG)) nx = 1;
         1: if (so) nx = 2; else if (!pfd) nx = 3;
         2: if (!so) nx = pfd ? 1 : 3;
         default: if (so) nx = 2; else if (pfd) nx = 1; else if (m_rec == TREC) nx = 0;
      endcase
      if (m_st == 0 && pfd && fast) m_lag = (m_lag < LAG) ? m_lag + 1 : LAG;
      else m_lag = 0;
      if (nx == 3) m_rec = (m_st == 3) ? m_rec + 1 : 1;
      else m_rec = 0;
      m_st = nx;
   endtask

   task automatic compare();
      int run;
      run = (m_st == 0) ? 1 : 0;
      chk(st == 2'(m_st), "R6 status", st, m_st);
      chk(ce_g == (ce && run == 1), "R2 ce_gated", ce_g, int'(ce && run == 1));
      chk(we_g == (we && run == 1), "R4 we_gated", we_g, int'(we && run == 1));
      chk(odis == (run == 0), "R3 out_dis", odis, int'(run == 0));
      chk(bsel == (m_st == 2), "R5 bat_sel", bsel, int'(m_st == 2));
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic tick(input logic p, input logic s, input logic f,
                       input logic c, input logic w);
      pfd = p; so = s && p; fast = f; ce = c; we = w;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
   endtask

   initial begin
      #(PERIOD * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n;
      logic [15:0] lf;
      logic p, s, f;
      repeat (3) @(negedge clk);
      // R1: reset state
      ce = 1'b1; we = 1'b1;
      chk(st == 2'b01, "R1 reset status", st, 1);
      chk(!we_g && !ce_g && odis && !bsel, "R1 reset outputs",
          {ce_g, we_g, odis, bsel}, 4'b0010);
      rst_n = 1'b1;

      // R6: count edges to normal
      n = 0;
      for (int i = 0; i < 40; i++) begin
         tick(0, 0, 0, 1, 1); n++;
         if (st == 2'b00) break;
      end
      chk(n == TREC + 1, "R6 reset-to-normal edges", n, TREC + 1);
      chk(ce_g && we_g, "R2 pass-through", {ce_g, we_g}, 3);

      // R8: fast-fall lag
      n = 0;
      for (int i = 0; i < 20; i++) begin
         tick(1, 0, 1, 1, 1);
         if (st != 2'b00) break;
         n++;
      end
      chk(n == LAG, "R8 lag edges in normal", n, LAG);
      chk(st == 2'b01, "R8 trip after lag", st, 1);

      // R7: recovery interrupted
      tick(0, 0, 0, 0, 1);
      tick(0, 0, 0, 0, 1);
      tick(0, 0, 0, 0, 1);
      tick(1, 0, 0, 0, 1);
      chk(st == 2'b01, "R7 reassert in recovery", st, 1);
      n = 0;
      for (int i = 0; i < 40; i++) begin
         tick(0, 0, 0, 1, 0); n++;
         if (st == 2'b00) break;
      end
      chk(n == TREC + 1, "R7 full interval after restart", n, TREC + 1);

      // R8: fast flag dropped mid-lag trips at next edge
      tick(1, 0, 1, 1, 1);
      chk(st == 2'b00, "R8 still normal", st, 0);
      tick(1, 0, 0, 1, 1);
      chk(st == 2'b01, "R8 trip on fast drop", st, 1);
      for (int i = 0; i < TREC + 1; i++) tick(0, 0, 0, 0, 0);
      chk(st == 2'b00, "R6 back to normal", st, 0);

      // R9 and R5
      tick(1, 1, 0, 1, 1);
      chk(st == 2'b10 && bsel, "R9 normal to battery", st, 2);
      chk(!we_g, "R4 no write in battery", we_g, 0);
      tick(1, 0, 0, 1, 1);
      chk(st == 2'b01 && !bsel, "R5 battery to deselect", st, 1);
      tick(1, 1, 0, 1, 1);
      tick(0, 0, 0, 1, 1);
      chk(st == 2'b11, "R5 battery to recovering", st, 3);

      // sweep
      lf = 16'hACE1; p = 1'b0; s = 1'b0; f = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (lf[3:0] == 4'h0) p = ~p;
         if (!p) s = 1'b0;
         else if (lf[7:4] == 4'h0) s = ~s;
         if (lf[10:8] == 3'h0) f = ~f;
         tick(p, s, f, lf[12], lf[13]);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule